// File: doc/BRIEF.md
# Per-lane read window edge search

This block searches for both boundaries of the valid read-data window of every data lane in one strobe group. It runs two sweeps. In the first sweep it steps one input delay that all data lanes share. In the second sweep it steps the strobe input delay upward from a starting value loaded by the caller. After each step the block raises a request. An outside read checker answers with a vector that has one pass bit per lane, and the block updates the stored edges of each lane from that vector.

Every edge is kept as a signed number. A non-negative value is the step at which the lane last passed. A negative value -(step+1) marks a failure that came before any pass, and it is stored on the opposite edge. A marker value of DQ_MAX+1 means no edge is known yet. The caller uses the edge values to centre each lane. The failing-lane vector shows which lanes ended the search without a complete window.

Top module: `deskew_edge_finder`

## Requirements
- R1: On reset, and in the cycle after a start is accepted, every left and right edge holds the marker value DQ_MAX+1 (16 with defaults).
- R2: The data sweep issues check number k (k from 0) with dq_dly = k, dqs_dly = the start value and en_dly = the enable start value. It goes no further than dq_dly = DQ_MAX.
- R3: In the data sweep, a lane whose pass bit is 1 stores the current step as its left edge. A lane whose pass bit is 0 and whose left edge is still the marker stores -(step+1) as its right edge.
- R4: In either sweep, a check ends that sweep without updating any edge when its pass vector is all zeros and the OR of all pass vectors seen so far in that sweep has every lane bit set. Otherwise the sweep runs to its last step.
- R5: Between the sweeps, dq_dly returns to 0. A lane that has a right edge but no left edge gets its right edge set back to the marker. The sticky OR restarts holding only the lanes that already have both edges.
- R6: The strobe sweep issues check s with dqs_dly = start+s, up to DQS_MAX. When SHIFT_EN is set, en_dly = min(enable start + s, EN_MAX).
- R7: In the strobe sweep, a pass stores s as the right edge. A failure at s > 0 on a lane whose right edge is still the marker stores -(s+1) as its left edge.
- R8: A failure at s = 0 on a lane with no right edge sets the right edge to -1 if the left edge is known. If the left edge is not known, the failure sets the left edge to -1.
- R9: At the end the block raises done for exactly one cycle. In that cycle, bit i of fail_lanes is 1 exactly when lane i still has a marker on either edge, and cal_fail is the OR of fail_lanes.
- R10: chk_req is a one-cycle pulse. No new request is raised until chk_valid has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| dqs_start | input | DW | Starting strobe input delay |
| en_start | input | DW | Starting strobe-enable delay |
| dq_dly | output | DW | Common data input delay to apply |
| dqs_dly | output | DW | Strobe input delay to apply |
| en_dly | output | DW | Strobe-enable delay to apply |
| chk_req | output | 1 | Request for one read check at the current delays |
| chk_valid | input | 1 | Check result is valid |
| chk_pass | input | LANES | Per-lane pass vector |
| left_edges | output | LANES*(DW+2) | Signed left edge per lane, lane i at bits i*(DW+2) |
| right_edges | output | LANES*(DW+2) | Signed right edge per lane, same packing |
| fail_lanes | output | LANES | Lanes lacking a complete window |
| cal_fail | output | 1 | Any lane lacks a window |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |

## Verification
The bench models each lane as a passing interval on one timing axis. Both sweeps move the lane along that axis, and some lanes are forced to fail at strobe step 0. Each scenario targets one corner case:
- The early stop rule. A design that ignores the sticky OR stops too soon or too late, so the check count and the edges are wrong.
- A lane that never passes in the data sweep. If the cleanup is missing, that lane keeps a stale negative right edge.
- A forced failure at strobe step 0. A design that applies only the general rule loses the -1 marginal marker.
- A start value close to the strobe limit. This shows an enable delay that runs past its clamp, or a sweep that overruns its end.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_WAIT,
    ST_MID,
    ST_FIN
  } fsm_e;

  typedef enum logic {
    SW_DATA,
    SW_STROBE
  } sweep_e;
endpackage

// File: rtl/dsk_lane_edges.sv
module dsk_lane_edges #(
  parameter int DW     = 4,
  parameter int DQ_MAX = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 upd_data,
  input  logic                 upd_strobe,
  input  logic                 mid_fix,
  input  logic [DW-1:0]        step,
  input  logic                 pass,
  output logic signed [DW+1:0] left_q,
  output logic signed [DW+1:0] right_q,
  output logic                 complete
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] MARK   = EW'(DQ_MAX + 1);
  localparam logic signed [EW-1:0] MINUS1 = EW'(-1);

  function automatic logic signed [EW-1:0] as_edge(input logic [DW-1:0] s);
    return $signed({2'b00, s});
  endfunction

  function automatic logic signed [EW-1:0] neg_step(input logic [DW-1:0] s);
    return -(as_edge(s) + EW'(1));
  endfunction

  logic left_known, right_known;
  assign left_known  = (left_q != MARK);
  assign right_known = (right_q != MARK);
  assign complete    = left_known && right_known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= MARK;
      right_q <= MARK;
    end else if (init) begin
      left_q  <= MARK;
      right_q <= MARK;
    end else if (upd_data) begin
      if (pass)             left_q  <= as_edge(step);
      else if (!left_known) right_q <= neg_step(step);
    end else if (mid_fix) begin
      if (!left_known && right_known) right_q <= MARK;
    end else if (upd_strobe) begin
      if (pass) begin
        right_q <= as_edge(step);
      end else if (step != '0) begin
        if (!right_known) left_q <= neg_step(step);
      end else if (!right_known) begin
        if (left_known) right_q <= MINUS1;
        else            left_q  <= MINUS1;
      end
    end
  end
endmodule

// File: rtl/dsk_sweep_ctrl.sv
module dsk_sweep_ctrl
  import deskew_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DW      = 4,
  parameter int DQ_MAX  = 15,
  parameter int DQS_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    dqs_start,
  input  logic [DW-1:0]    en_start,
  input  logic             chk_valid,
  input  logic [LANES-1:0] chk_pass,
  input  logic [LANES-1:0] lanes_complete,
  output sweep_e           sweep_o,
  output logic [DW-1:0]    step_o,
  output logic [DW-1:0]    dqs_base,
  output logic [DW-1:0]    en_base,
  output logic             chk_req,
  output logic             lane_init,
  output logic             upd_data,
  output logic             upd_strobe,
  output logic             mid_fix,
  output logic             busy,
  output logic             done
);
  localparam logic [DW-1:0] DQ_LIM  = DW'(DQ_MAX);
  localparam logic [DW:0]   DQS_LIM = (DW + 1)'(DQS_MAX);

  fsm_e             state;
  sweep_e           sweep;
  logic [DW-1:0]    step;
  logic [LANES-1:0] sticky;

  logic [LANES-1:0] sticky_nx;
  logic             stop, accept, last_step, skip_strobe;
  logic [DW:0]      span;

  assign sticky_nx   = sticky | chk_pass;
  assign stop        = (chk_pass == '0) && (sticky_nx == '1);
  assign accept      = (state == ST_WAIT) && chk_valid;
  assign span        = DQS_LIM - {1'b0, dqs_base};
  assign skip_strobe = ({1'b0, dqs_base} > DQS_LIM);
  assign last_step   = (sweep == SW_DATA) ? (step == DQ_LIM)
                                          : ({1'b0, step} == span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sweep    <= SW_DATA;
      step     <= '0;
      sticky   <= '0;
      dqs_base <= '0;
      en_base  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_PROBE;
          sweep    <= SW_DATA;
          step     <= '0;
          sticky   <= '0;
          dqs_base <= dqs_start;
          en_base  <= en_start;
        end
        ST_PROBE: state <= ST_WAIT;
        ST_WAIT: if (chk_valid) begin
          sticky <= sticky_nx;
          if (stop || last_step) begin
            state <= (sweep == SW_DATA) ? ST_MID : ST_FIN;
          end else begin
            step  <= step + 1'b1;
            state <= ST_PROBE;
          end
        end
        ST_MID: begin
          step   <= '0;
          sticky <= lanes_complete;
          if (skip_strobe) state <= ST_FIN;
          else begin
            sweep <= SW_STROBE;
            state <= ST_PROBE;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sweep_o    = sweep;
  assign step_o     = step;
  assign chk_req    = (state == ST_PROBE);
  assign lane_init  = (state == ST_IDLE) && start;
  assign upd_data   = accept && !stop && (sweep == SW_DATA);
  assign upd_strobe = accept && !stop && (sweep == SW_STROBE);
  assign mid_fix    = (state == ST_MID);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
endmodule

// File: rtl/dsk_delay_map.sv
module dsk_delay_map
  import deskew_pkg::*;
#(
  parameter int DW       = 4,
  parameter int EN_MAX   = 12,
  parameter bit SHIFT_EN = 1'b1
) (
  input  sweep_e        sweep,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] dqs_base,
  input  logic [DW-1:0] en_base,
  output logic [DW-1:0] dq_dly,
  output logic [DW-1:0] dqs_dly,
  output logic [DW-1:0] en_dly
);
  function automatic logic [DW-1:0] clamp_add(input logic [DW-1:0] base,
                                              input logic [DW-1:0] off);
    logic [DW:0] sum;
    sum = {1'b0, base} + {1'b0, off};
    return (sum > (DW + 1)'(EN_MAX)) ? DW'(EN_MAX) : sum[DW-1:0];
  endfunction

  assign dq_dly  = (sweep == SW_DATA) ? step : '0;
  assign dqs_dly = (sweep == SW_STROBE) ? dqs_base + step : dqs_base;

  generate
    if (SHIFT_EN) begin : g_shift
      assign en_dly = (sweep == SW_STROBE) ? clamp_add(en_base, step) : en_base;
    end else begin : g_fixed
      assign en_dly = en_base;
    end
  endgenerate
endmodule

// File: rtl/deskew_edge_finder.sv
module deskew_edge_finder
  import deskew_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int DW       = 4,
  parameter int DQ_MAX   = 15,
  parameter int DQS_MAX  = 15,
  parameter int EN_MAX   = 12,
  parameter bit SHIFT_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [DW-1:0]             dqs_start,
  input  logic [DW-1:0]             en_start,
  output logic [DW-1:0]             dq_dly,
  output logic [DW-1:0]             dqs_dly,
  output logic [DW-1:0]             en_dly,
  output logic                      chk_req,
  input  logic                      chk_valid,
  input  logic [LANES-1:0]          chk_pass,
  output logic [LANES*(DW+2)-1:0]   left_edges,
  output logic [LANES*(DW+2)-1:0]   right_edges,
  output logic [LANES-1:0]          fail_lanes,
  output logic                      cal_fail,
  output logic                      busy,
  output logic                      done
);
  localparam int EW = DW + 2;

  sweep_e           sweep;
  logic [DW-1:0]    step;
  logic [DW-1:0]    dqs_base, en_base;
  logic             lane_init, upd_data, upd_strobe, mid_fix;
  logic [LANES-1:0] lanes_complete;
  logic             in_data, in_strobe;

  dsk_sweep_ctrl #(
    .LANES(LANES), .DW(DW), .DQ_MAX(DQ_MAX), .DQS_MAX(DQS_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dqs_start(dqs_start), .en_start(en_start),
    .chk_valid(chk_valid), .chk_pass(chk_pass),
    .lanes_complete(lanes_complete),
    .sweep_o(sweep), .step_o(step),
    .dqs_base(dqs_base), .en_base(en_base),
    .chk_req(chk_req), .lane_init(lane_init),
    .upd_data(upd_data), .upd_strobe(upd_strobe),
    .mid_fix(mid_fix), .busy(busy), .done(done)
  );

  dsk_delay_map #(
    .DW(DW), .EN_MAX(EN_MAX), .SHIFT_EN(SHIFT_EN)
  ) u_map (
    .sweep(sweep), .step(step), .dqs_base(dqs_base), .en_base(en_base),
    .dq_dly(dq_dly), .dqs_dly(dqs_dly), .en_dly(en_dly)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic signed [EW-1:0] l_edge, r_edge;
      dsk_lane_edges #(.DW(DW), .DQ_MAX(DQ_MAX)) u_lane (
        .clk(clk), .rst_n(rst_n), .init(lane_init),
        .upd_data(upd_data), .upd_strobe(upd_strobe), .mid_fix(mid_fix),
        .step(step), .pass(chk_pass[i]),
        .left_q(l_edge), .right_q(r_edge), .complete(lanes_complete[i])
      );
      assign left_edges[i*EW +: EW]  = l_edge;
      assign right_edges[i*EW +: EW] = r_edge;
    end
  endgenerate

  assign fail_lanes = ~lanes_complete;
  assign cal_fail   = |fail_lanes;
  assign in_data    = busy && (sweep == SW_DATA);
  assign in_strobe  = busy && (sweep == SW_STROBE);
endmodule

// File: rtl/deskew_edge_chk.sv
module deskew_edge_chk #(
  parameter int LANES    = 4,
  parameter int DW       = 4,
  parameter int DQ_MAX   = 15,
  parameter int EN_MAX   = 12,
  parameter bit SHIFT_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    chk_req,
  input logic                    chk_valid,
  input logic                    done,
  input logic                    lane_init,
  input logic                    mid_fix,
  input logic                    in_data,
  input logic                    in_strobe,
  input logic [DW-1:0]           dq_dly,
  input logic [DW-1:0]           en_dly,
  input logic [LANES*(DW+2)-1:0] left_edges,
  input logic [LANES*(DW+2)-1:0] right_edges
);
  localparam int EW = DW + 2;
  localparam logic [EW-1:0]       MARK_V   = EW'(DQ_MAX + 1);
  localparam logic [LANES*EW-1:0] ALL_MARK = {LANES{MARK_V}};

  logic          pending;
  logic          have_prev;
  logic [DW-1:0] prev_dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      have_prev <= 1'b0;
      prev_dq   <= '0;
    end else begin
      if (chk_req)        pending <= 1'b1;
      else if (chk_valid) pending <= 1'b0;
      if (lane_init) have_prev <= 1'b0;
      else if (chk_req && in_data) begin
        have_prev <= 1'b1;
        prev_dq   <= dq_dly;
      end
    end
  end

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> !chk_req);

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !pending);

  assert_data_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && in_data && have_prev) |-> (dq_dly == prev_dq + 1'b1));

  assert_cleanup_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_fix |=> (dq_dly == '0));

  assert_init_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_init |=> (left_edges == ALL_MARK && right_edges == ALL_MARK));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  generate
    if (SHIFT_EN) begin : g_en_chk
      assert_en_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && in_strobe) |-> (en_dly <= DW'(EN_MAX)));
    end
  endgenerate
endmodule

bind deskew_edge_finder deskew_edge_chk #(
  .LANES(LANES), .DW(DW), .DQ_MAX(DQ_MAX), .EN_MAX(EN_MAX), .SHIFT_EN(SHIFT_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_valid(chk_valid),
  .done(done), .lane_init(lane_init), .mid_fix(mid_fix),
  .in_data(in_data), .in_strobe(in_strobe), .dq_dly(dq_dly), .en_dly(en_dly),
  .left_edges(left_edges), .right_edges(right_edges)
);

// File: tb/deskew_edge_finder_tb.sv
module deskew_edge_finder_tb;
  localparam int LANES = 4;
  localparam int DW    = 4;
  localparam int EW    = DW + 2;
  localparam int DQMX  = 15;
  localparam int DQSMX = 15;
  localparam int ENMX  = 12;
  localparam int MARK  = DQMX + 1;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [DW-1:0]          dqs_start = '0;
  logic [DW-1:0]          en_start = '0;
  logic [DW-1:0]          dq_dly, dqs_dly, en_dly;
  logic                   chk_req;
  logic                   chk_valid;
  logic [LANES-1:0]       chk_pass;
  logic [LANES*EW-1:0]    left_edges, right_edges;
  logic [LANES-1:0]       fail_lanes;
  logic                   cal_fail, busy, done;

  always #5 clk = ~clk;

  deskew_edge_finder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dqs_start(dqs_start),
    .en_start(en_start), .dq_dly(dq_dly), .dqs_dly(dqs_dly), .en_dly(en_dly),
    .chk_req(chk_req), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .left_edges(left_edges), .right_edges(right_edges),
    .fail_lanes(fail_lanes), .cal_fail(cal_fail), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // lane model: lane passes when timing position t is inside [lo,hi]
  // data step d sits at t = DQMX - d, strobe step s at t = DQMX + s
  int lo [LANES];
  int hi [LANES];
  logic [LANES-1:0] glitch0;
  int st_base, en_base_tb;
  int exp_l [LANES];
  int exp_r [LANES];
  int nd_exp, ns_exp;
  int probe_idx;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] pvec(input bit strobe, input int k);
    logic [LANES-1:0] v;
    int t;
    t = strobe ? DQMX + k : DQMX - k;
    for (int l = 0; l < LANES; l++) begin
      v[l] = (t >= lo[l]) && (t <= hi[l]);
      if (strobe && k == 0 && glitch0[l]) v[l] = 1'b0;
    end
    return v;
  endfunction

  task automatic reference();
    logic [LANES-1:0] sticky, p;
    for (int l = 0; l < LANES; l++) begin exp_l[l] = MARK; exp_r[l] = MARK; end
    sticky = '0; nd_exp = 0; ns_exp = 0;
    for (int d = 0; d <= DQMX; d++) begin
      p = pvec(1'b0, d); nd_exp++; sticky |= p;
      if (p == '0 && sticky == '1) break;
      for (int l = 0; l < LANES; l++)
        if (p[l]) exp_l[l] = d;
        else if (exp_l[l] == MARK) exp_r[l] = -(d + 1);
    end
    sticky = '0;
    for (int l = 0; l < LANES; l++) begin
      if (exp_l[l] == MARK) exp_r[l] = MARK;
      sticky[l] = (exp_l[l] != MARK) && (exp_r[l] != MARK);
    end
    for (int s = 0; s <= DQSMX - st_base; s++) begin
      p = pvec(1'b1, s); ns_exp++; sticky |= p;
      if (p == '0 && sticky == '1) break;
      for (int l = 0; l < LANES; l++)
        if (p[l]) exp_r[l] = s;
        else if (exp_r[l] == MARK) begin
          if (s != 0)               exp_l[l] = -(s + 1);
          else if (exp_l[l] != MARK) exp_r[l] = -1;
          else                      exp_l[l] = -1;
        end
    end
  endtask

  function automatic int edge_of(input logic [LANES*EW-1:0] v, input int l);
    logic signed [EW-1:0] e;
    e = v[l*EW +: EW];
    return int'(e);
  endfunction

  // read-check responder
  initial begin
    chk_valid = 1'b0;
    chk_pass  = '0;
    forever begin
      @(negedge clk);
      chk_valid = 1'b0;
      if (chk_req) begin
        logic [LANES-1:0] p;
        int k, en_exp;
        if (probe_idx < nd_exp) begin
          k = probe_idx;
          check(dq_dly == DW'(k), "R2 dq_dly", int'(dq_dly), k);
          check(dqs_dly == DW'(st_base), "R2 dqs_dly", int'(dqs_dly), st_base);
          check(en_dly == DW'(en_base_tb), "R2 en_dly", int'(en_dly), en_base_tb);
          p = pvec(1'b0, k);
        end else begin
          k = probe_idx - nd_exp;
          en_exp = (en_base_tb + k > ENMX) ? ENMX : en_base_tb + k;
          check(dq_dly == '0, "R5 dq_dly zero", int'(dq_dly), 0);
          check(dqs_dly == DW'(st_base + k), "R6 dqs_dly", int'(dqs_dly), st_base + k);
          check(en_dly == DW'(en_exp), "R6 en_dly", int'(en_dly), en_exp);
          p = pvec(1'b1, k);
        end
        probe_idx++;
        @(negedge clk);
        check(chk_req == 1'b0, "R10 req pulse", int'(chk_req), 0);
        chk_valid = 1'b1;
        chk_pass  = p;
      end
    end
  end

  task automatic run_case(input string name, input int st, input int en);
    logic fexp;
    logic any;
    int   guard;
    st_base = st; en_base_tb = en;
    reference();
    probe_idx = 0;
    @(negedge clk);
    dqs_start = DW'(st); en_start = DW'(en); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      check(edge_of(left_edges, l) == MARK, "R1 left init", edge_of(left_edges, l), MARK);
      check(edge_of(right_edges, l) == MARK, "R1 right init", edge_of(right_edges, l), MARK);
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done == 1'b1, {"R9 done seen ", name}, int'(done), 1);
    any = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      check(edge_of(left_edges, l) == exp_l[l], {"R3/R7/R8 left ", name},
            edge_of(left_edges, l), exp_l[l]);
      check(edge_of(right_edges, l) == exp_r[l], {"R3/R5/R7/R8 right ", name},
            edge_of(right_edges, l), exp_r[l]);
      fexp = (exp_l[l] == MARK) || (exp_r[l] == MARK);
      any |= fexp;
      check(fail_lanes[l] == fexp, {"R9 fail lane ", name}, int'(fail_lanes[l]), int'(fexp));
    end
    check(cal_fail == any, {"R9 cal_fail ", name}, int'(cal_fail), int'(any));
    check(probe_idx == nd_exp + ns_exp, {"R4 check count ", name}, probe_idx, nd_exp + ns_exp);
    @(negedge clk);
    check(done == 1'b0, {"R9 done one cycle ", name}, int'(done), 0);
    check(busy == 1'b0, {"R9 idle after ", name}, int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    nd_exp = 0; probe_idx = 0; glitch0 = '0;
    st_base = 0; en_base_tb = 0;
    for (int l = 0; l < LANES; l++) begin lo[l] = 0; hi[l] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset idle", int'(busy), 0);
    check(chk_req == 1'b0, "R10 reset no req", int'(chk_req), 0);
    check(dq_dly == '0, "R1 reset dq", int'(dq_dly), 0);
    for (int l = 0; l < LANES; l++)
      check(edge_of(left_edges, l) == MARK, "R1 reset marker", edge_of(left_edges, l), MARK);
    rst_n = 1'b1;

    // mixed windows
    lo[0] = 10; hi[0] = 20; lo[1] = 13; hi[1] = 17;
    lo[2] = 0;  hi[2] = 30; lo[3] = 14; hi[3] = 14;
    run_case("mixed", 0, 3);

    // early stop in data sweep, full strobe run (R4)
    for (int l = 0; l < LANES; l++) begin lo[l] = 12; hi[l] = 30; end
    run_case("early stop", 0, 0);

    // lane absent from data sweep (R5) and a dead lane (R9)
    lo[0] = 20; hi[0] = 25; lo[1] = 40; hi[1] = 41;
    lo[2] = 5;  hi[2] = 16; lo[3] = 15; hi[3] = 15;
    run_case("cleanup", 0, 5);

    // marginal failures at strobe step 0 (R8), clamped enable (R6)
    lo[0] = 10; hi[0] = 20; lo[1] = 16; hi[1] = 20;
    lo[2] = 0;  hi[2] = 15; lo[3] = 13; hi[3] = 28;
    glitch0 = 4'b0111;
    run_case("marginal", 4, 9);
    glitch0 = '0;

    // start near the strobe limit
    lo[0] = 14; hi[0] = 30; lo[1] = 11; hi[1] = 16;
    lo[2] = 15; hi[2] = 17; lo[3] = 2;  hi[3] = 15;
    run_case("high start", 13, 11);

    // stop inside the strobe sweep (R4)
    for (int l = 0; l < LANES; l++) begin lo[l] = 8 + l; hi[l] = 18; end
    run_case("strobe stop", 2, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule